// File: doc/BRIEF.md
# Predicate Register File with Commit Qualification

This block keeps a small file of one-bit predicate flags and uses them to decide whether each issued instruction may change architectural state. Instructions are never steered around: each one presents the index of the predicate that guards it, and one cycle later the block returns a commit enable. When that enable is low, writeback logic treats the instruction as a no-op.

Predicate flags change only through the compare port. One compare result writes a pair of flags in the same cycle. The first target receives the result and the second target receives its inverse. Entry 0 always reads as true, so unguarded instructions can name it, and writes aimed at it are dropped. When a qualify lookup names a flag that a compare writes in the same cycle, the lookup sees the new value.

Top module: `pred_qualify_unit`

## Requirements
- R1: After synchronous reset, every predicate entry except entry 0 reads 0, and both `commit_en` and `commit_vld` are low.
- R2: A lookup presented with `qual_vld` high at a rising edge drives `commit_vld` high after that edge. At the same edge `commit_en` takes the value of the named predicate.
- R3: Entry 0 always reads 1. A compare that targets entry 0 with either index leaves it unchanged.
- R4: A compare accepted with `cmp_vld` high writes `cmp_res` into entry `cmp_tgt_t` and the inverse of `cmp_res` into entry `cmp_tgt_f`. Both writes land at the same edge.
- R5: When `cmp_tgt_t` equals `cmp_tgt_f` and is not 0, that entry takes `cmp_res`.
- R6: While `cmp_vld` is low, no predicate entry changes, whatever the target indices and result are.
- R7: A lookup that names an entry a compare writes in the same cycle returns the newly written value, with the priority of R5.
- R8: While `qual_vld` is low, `commit_en` and `commit_vld` are 0 after the next edge, whatever value the named predicate holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_vld | input | 1 | Compare result is valid this cycle |
| cmp_res | input | 1 | Outcome of the compare |
| cmp_tgt_t | input | IDX_W | Entry that receives the outcome |
| cmp_tgt_f | input | IDX_W | Entry that receives the inverted outcome |
| qual_vld | input | 1 | Instruction lookup is valid this cycle |
| qual_idx | input | IDX_W | Predicate entry that guards the instruction |
| commit_vld | output | 1 | Registered: a lookup result is presented |
| commit_en | output | 1 | Registered: the instruction may update state |

## Verification
The bench builds the unit with 8 predicate entries and a 3-bit index. At that size every pair of true and false targets can be tried with both compare outcomes, and every entry can be read back after each compare, so entry 0, coinciding targets and every bypass case are all reached. The bench also exercises same-cycle forwarding for every nonzero entry, compares that are not valid but carry live indices, and lookups that are not valid and name a set predicate.

// File: rtl/pq_pkg.sv
package pq_pkg;

  localparam int unsigned PQ_DEF_ENTRIES = 64;

  // Next value of one predicate entry. The true-target write wins over the
  // false-target write when both hit the same entry.
  function automatic logic pq_next(input logic hit_t, input logic hit_f,
                                   input logic res, input logic cur);
    if (hit_t)      return res;
    else if (hit_f) return ~res;
    else            return cur;
  endfunction

endpackage

// File: rtl/pq_pred_file.sv
module pq_pred_file #(
  parameter int unsigned ENTRIES = pq_pkg::PQ_DEF_ENTRIES,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_vld,
  input  logic               wr_res,
  input  logic [IDX_W-1:0]   wr_tgt_t,
  input  logic [IDX_W-1:0]   wr_tgt_f,
  output logic [ENTRIES-1:0] flags
);
  import pq_pkg::*;

  logic [ENTRIES-1:1] store_q;

  assign flags[0] = 1'b1;

  for (genvar e = 1; e < ENTRIES; e++) begin : g_entry
    logic hit_t, hit_f;
    assign hit_t = wr_vld && (wr_tgt_t == IDX_W'(e));
    assign hit_f = wr_vld && (wr_tgt_f == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) store_q[e] <= 1'b0;
      else     store_q[e] <= pq_next(hit_t, hit_f, wr_res, store_q[e]);
    end

    assign flags[e] = store_q[e];
  end

  // R4: both targets land on the same edge
  p_true_lands_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && wr_tgt_t != '0) |=> flags[$past(wr_tgt_t)] == $past(wr_res));
  p_false_lands_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && wr_tgt_f != '0 && wr_tgt_f != wr_tgt_t)
      |=> flags[$past(wr_tgt_f)] == !$past(wr_res));
  // R6: no write without a valid compare
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_vld |=> $stable(flags));
  // R3: entry 0 pinned true
  p_zero_true_r3: assert property (@(posedge clk) disable iff (rst)
    flags[0]);

endmodule

// File: rtl/pq_bypass_read.sv
module pq_bypass_read #(
  parameter int unsigned ENTRIES = pq_pkg::PQ_DEF_ENTRIES,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] flags,
  input  logic               wr_vld,
  input  logic               wr_res,
  input  logic [IDX_W-1:0]   wr_tgt_t,
  input  logic [IDX_W-1:0]   wr_tgt_f,
  input  logic               rd_vld,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               out_vld,
  output logic               out_en
);
  import pq_pkg::*;

  logic nonzero, byp_t, byp_f, pred_now;

  assign nonzero  = (rd_idx != '0);
  assign byp_t    = wr_vld && nonzero && (wr_tgt_t == rd_idx);
  assign byp_f    = wr_vld && nonzero && (wr_tgt_f == rd_idx);
  assign pred_now = pq_next(byp_t, byp_f, wr_res, flags[rd_idx]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_en  <= 1'b0;
    end else begin
      out_vld <= rd_vld;
      out_en  <= rd_vld && pred_now;
    end
  end

  // R8: enable never without a presented lookup
  p_en_needs_vld_r8: assert property (@(posedge clk) disable iff (rst)
    out_en |-> out_vld);
  // R3: entry 0 always commits
  p_zero_commits_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && rd_idx == '0) |=> out_en);
  // R7: same-cycle true-target write is forwarded
  p_fwd_true_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && wr_vld && nonzero && wr_tgt_t == rd_idx) |=> out_en == $past(wr_res));

endmodule

// File: rtl/pred_qualify_unit.sv
module pred_qualify_unit #(
  parameter int unsigned ENTRIES = pq_pkg::PQ_DEF_ENTRIES,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_vld,
  input  logic             cmp_res,
  input  logic [IDX_W-1:0] cmp_tgt_t,
  input  logic [IDX_W-1:0] cmp_tgt_f,
  input  logic             qual_vld,
  input  logic [IDX_W-1:0] qual_idx,
  output logic             commit_vld,
  output logic             commit_en
);

  logic [ENTRIES-1:0] flags;

  pq_pred_file #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) file_i (
    .clk(clk), .rst(rst),
    .wr_vld(cmp_vld), .wr_res(cmp_res),
    .wr_tgt_t(cmp_tgt_t), .wr_tgt_f(cmp_tgt_f),
    .flags(flags)
  );

  pq_bypass_read #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) rd_i (
    .clk(clk), .rst(rst), .flags(flags),
    .wr_vld(cmp_vld), .wr_res(cmp_res),
    .wr_tgt_t(cmp_tgt_t), .wr_tgt_f(cmp_tgt_f),
    .rd_vld(qual_vld), .rd_idx(qual_idx),
    .out_vld(commit_vld), .out_en(commit_en)
  );

  // R2: a lookup is answered on the following edge
  p_answer_next_r2: assert property (@(posedge clk) disable iff (rst)
    qual_vld |=> commit_vld);
  // R8: no lookup, no answer
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !qual_vld |=> !commit_vld && !commit_en);

endmodule

// File: tb/pred_qualify_unit_tb.sv
module pred_qualify_unit_tb_top;
  localparam int unsigned N = 8;
  localparam int unsigned W = 3;

  logic clk = 1'b0;
  logic rst;
  logic cmp_vld, cmp_res, qual_vld;
  logic [W-1:0] cmp_tgt_t, cmp_tgt_f, qual_idx;
  logic commit_vld, commit_en;

  int total = 0;
  int bad   = 0;
  logic model [N];

  always #5 clk = ~clk;

  pred_qualify_unit #(.ENTRIES(N), .IDX_W(W)) dut_i (
    .clk(clk), .rst(rst),
    .cmp_vld(cmp_vld), .cmp_res(cmp_res),
    .cmp_tgt_t(cmp_tgt_t), .cmp_tgt_f(cmp_tgt_f),
    .qual_vld(qual_vld), .qual_idx(qual_idx),
    .commit_vld(commit_vld), .commit_en(commit_en)
  );

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, update the model, check at the next falling edge.
  task automatic cycle(input logic cv, input logic r, input int t, input int f,
                       input logic qv, input int qi, input string req);
    logic exp_en;
    cmp_vld = cv; cmp_res = r; cmp_tgt_t = W'(t); cmp_tgt_f = W'(f);
    qual_vld = qv; qual_idx = W'(qi);
    if (cv) begin
      if (f != 0) model[f] = ~r;
      if (t != 0) model[t] = r;
    end
    exp_en = qv && model[qi];
    @(negedge clk);
    check(commit_vld, qv, req);
    check(commit_en, exp_en, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cmp_vld = 0; cmp_res = 0; cmp_tgt_t = 0; cmp_tgt_f = 0;
    qual_vld = 0; qual_idx = 0;
    for (int i = 0; i < N; i++) model[i] = (i == 0);
    repeat (3) @(negedge clk);
    check(commit_vld, 1'b0, "R1");
    check(commit_en, 1'b0, "R1");
    rst = 1'b0;

    // R1: reset contents
    for (int i = 0; i < N; i++) cycle(0, 0, 0, 0, 1, i, "R1");

    // R4, R5, R3: every target pair and outcome, full readback
    for (int t = 0; t < N; t++)
      for (int f = 0; f < N; f++)
        for (int r = 0; r < 2; r++) begin
          cycle(1, r[0], t, f, 0, 0, "R4");
          for (int i = 0; i < N; i++)
            cycle(0, 0, 0, 0, 1, i,
                  (i == 0) ? "R3" : ((t == f) ? "R5" : "R4"));
        end

    // R7: forwarding of both targets and of coinciding targets
    for (int i = 1; i < N; i++)
      for (int r = 0; r < 2; r++) begin
        cycle(1, r[0], i, (i % (N - 1)) + 1, 1, i, "R7");
        cycle(1, r[0], (i % (N - 1)) + 1, i, 1, i, "R7");
        cycle(1, r[0], i, i, 1, i, "R7");
      end

    // R6: idle compare with live indices changes nothing
    for (int i = 1; i < N; i++) begin
      cycle(0, ~model[i], i, i, 1, i, "R6");
      cycle(0, 0, 0, 0, 1, i, "R6");
    end

    // R8: lookup not valid while the named predicate is set
    cycle(1, 1, 3, 4, 0, 0, "R8");
    cycle(0, 0, 0, 0, 0, 3, "R8");
    cycle(0, 0, 0, 0, 0, 0, "R8");
    cycle(0, 0, 0, 0, 1, 3, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule